// File: doc/BRIEF.md
# Open-Drain Line Repeater with Edge Arbitration

The block joins a host-side data line to a card-side data line, where both lines are open-drain with pull-ups, for several lanes at once. With no transfer in progress, it drives nothing and both lines rest high. Whichever side of a lane is first seen falling becomes the master for that transfer. After a fixed delay, the block pulls the other side (the slave) low, so the low level is copied across. Falling edges on the slave side are ignored until the transfer has finished.

When the master side goes high again, the block releases the slave's pull-low and enables a pull-high driver on the slave for one delay interval. This speeds up the rising edge. The lane then returns to idle.

A session enable gates the whole block. While it is low, no driver is enabled and any transfer is dropped. Each line input passes through a synchroniser, and all timing is counted in system clocks.

Top module: `od_line_repeater`

## Requirements
- R1: After reset, and whenever a lane is idle, all four driver enables of that lane are 0. Bit i of every vector port belongs to lane i.
- R2: The first side whose synchronised level falls becomes master. If both sides fall in the same cycle, the host side wins. The master side's own enables stay 0 for the whole transfer.
- R3: The slave pull-low enable rises on the EDGE_DLY+3rd rising clock edge, counting the first edge that samples the master line low. It is still 0 at the edge before.
- R4: During a transfer, slave-line activity changes neither the direction nor the master-side enables.
- R5: The master line is released while the slave is pulled low. On the 3rd rising edge that samples the master high, the slave pull-low drops and the slave pull-high rises. The pull-high lasts exactly EDGE_DLY cycles, and the lane is then idle.
- R6: On either side of a lane, the pull-low enable and the pull-high enable are never 1 together.
- R7: If the master releases before the delay expires, nothing is driven and the lane returns to idle.
- R8: A falling edge during the pull-high pulse is not accepted, and a line still held low at the end of the pulse does not start a transfer. A later fresh falling edge does start one.
- R9: At the first rising edge that samples the session enable low, every enable goes to 0. While the session enable stays low, no transfer starts.
- R10: Lanes are independent: a transfer on one lane leaves the other lanes' enables at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sess_en_i | input | 1 | Session enable; low forces all lanes idle |
| host_line_i | input | NUM_LINES | Sampled host-side line levels |
| card_line_i | input | NUM_LINES | Sampled card-side line levels |
| host_pull_lo_o | output | NUM_LINES | Host-side pull-low enable |
| host_pull_hi_o | output | NUM_LINES | Host-side active pull-high enable |
| card_pull_lo_o | output | NUM_LINES | Card-side pull-low enable |
| card_pull_hi_o | output | NUM_LINES | Card-side active pull-high enable |

## Verification
Two arbitration events can land in the same cycle: a falling edge on the host side and a falling edge on the card side. The bench provokes this by pulling both external drivers of one lane low on the same clock edge. It judges the result by checking that only the card-side pull-low comes on, at the exact delay, while the host-side enables stay off. A second same-cycle case drops the session enable during the copy phase; the bench expects every enable to be off at the very next edge, with no pull-high pulse afterwards.

// File: rtl/od_repeater_pkg.sv
`timescale 1ns/1ps
package od_repeater_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_COPY  = 2'd2,
    ST_BOOST = 2'd3
  } lane_state_e;

  typedef enum logic {
    SIDE_HOST = 1'b0,
    SIDE_CARD = 1'b1
  } side_e;
endpackage

// File: rtl/od_line_sync.sv
`timescale 1ns/1ps
module od_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic lvl_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], line_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign fall_o = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/od_repeater_lane.sv
`timescale 1ns/1ps
module od_repeater_lane
  import od_repeater_pkg::*;
#(
  parameter int EDGE_DLY = 50,
  parameter int SYNC_STG = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sess_en_i,
  input  logic host_line_i,
  input  logic card_line_i,
  output logic host_lo_o,
  output logic host_hi_o,
  output logic card_lo_o,
  output logic card_hi_o
);
  localparam int CW = $clog2(EDGE_DLY + 1);
  localparam logic [CW-1:0] LOAD = CW'(EDGE_DLY - 1);

  logic host_lvl, host_fall, card_lvl, card_fall, mst_lvl;
  lane_state_e state_q;
  side_e       mst_q;
  logic [CW-1:0] cnt_q;

  od_line_sync #(.STAGES(SYNC_STG)) u_host_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(host_line_i),
    .lvl_o(host_lvl), .fall_o(host_fall)
  );
  od_line_sync #(.STAGES(SYNC_STG)) u_card_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(card_line_i),
    .lvl_o(card_lvl), .fall_o(card_fall)
  );

  assign mst_lvl = (mst_q == SIDE_HOST) ? host_lvl : card_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mst_q   <= SIDE_HOST;
      cnt_q   <= '0;
    end else if (!sess_en_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          // host wins a same-cycle tie
          if (host_fall) begin
            mst_q   <= SIDE_HOST;
            state_q <= ST_WAIT;
            cnt_q   <= LOAD;
          end else if (card_fall) begin
            mst_q   <= SIDE_CARD;
            state_q <= ST_WAIT;
            cnt_q   <= LOAD;
          end
        end
        ST_WAIT: begin
          if (mst_lvl)          state_q <= ST_IDLE;
          else if (cnt_q == '0) state_q <= ST_COPY;
          else                  cnt_q   <= cnt_q - 1'b1;
        end
        ST_COPY: begin
          if (mst_lvl) begin
            state_q <= ST_BOOST;
            cnt_q   <= LOAD;
          end
        end
        ST_BOOST: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign card_lo_o = (state_q == ST_COPY)  && (mst_q == SIDE_HOST);
  assign card_hi_o = (state_q == ST_BOOST) && (mst_q == SIDE_HOST);
  assign host_lo_o = (state_q == ST_COPY)  && (mst_q == SIDE_CARD);
  assign host_hi_o = (state_q == ST_BOOST) && (mst_q == SIDE_CARD);

  a_r6_card_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(card_lo_o && card_hi_o));
  a_r6_host_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_lo_o && host_hi_o));
  a_r9_sess_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sess_en_i |=> !(host_lo_o || host_hi_o || card_lo_o || card_hi_o));
  a_r5_card_boost_after_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(card_hi_o) |-> $past(card_lo_o));
  a_r5_host_boost_after_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_hi_o) |-> $past(host_lo_o));
  a_r3_card_copy_needs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(card_lo_o) |-> $past(!host_lvl));
  a_r3_host_copy_needs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_lo_o) |-> $past(!card_lvl));
endmodule

// File: rtl/od_line_repeater.sv
`timescale 1ns/1ps
module od_line_repeater #(
  parameter int NUM_LINES = 3,
  parameter int EDGE_DLY  = 50,
  parameter int SYNC_STG  = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sess_en_i,
  input  logic [NUM_LINES-1:0] host_line_i,
  input  logic [NUM_LINES-1:0] card_line_i,
  output logic [NUM_LINES-1:0] host_pull_lo_o,
  output logic [NUM_LINES-1:0] host_pull_hi_o,
  output logic [NUM_LINES-1:0] card_pull_lo_o,
  output logic [NUM_LINES-1:0] card_pull_hi_o
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_lane
    od_repeater_lane #(.EDGE_DLY(EDGE_DLY), .SYNC_STG(SYNC_STG)) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sess_en_i  (sess_en_i),
      .host_line_i(host_line_i[i]),
      .card_line_i(card_line_i[i]),
      .host_lo_o  (host_pull_lo_o[i]),
      .host_hi_o  (host_pull_hi_o[i]),
      .card_lo_o  (card_pull_lo_o[i]),
      .card_hi_o  (card_pull_hi_o[i])
    );
  end
endmodule

// File: tb/tb_od_line_repeater.sv
`timescale 1ns/1ps
module tb_od_line_repeater;
  localparam int LANES = 3;
  localparam int EDGE  = 50;
  // columns: lane, master side (0 host, 1 card), low cycles
  localparam int NVEC = 4;
  localparam int VEC [NVEC][3] = '{'{0, 0, 60}, '{1, 1, 80}, '{2, 0, 55}, '{0, 1, 100}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sess = 1'b1;
  logic [LANES-1:0] host_ext = '0, card_ext = '0;
  logic [LANES-1:0] host_line, card_line, host_lo, host_hi, card_lo, card_hi;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign host_line = ~(host_ext | host_lo);
  assign card_line = ~(card_ext | card_lo);

  od_line_repeater #(.NUM_LINES(LANES), .EDGE_DLY(EDGE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sess_en_i(sess),
    .host_line_i(host_line), .card_line_i(card_line),
    .host_pull_lo_o(host_lo), .host_pull_hi_o(host_hi),
    .card_pull_lo_o(card_lo), .card_pull_hi_o(card_hi)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    end
  endtask

  function automatic int s_lo(int ln, bit fc); return fc ? host_lo[ln] : card_lo[ln]; endfunction
  function automatic int s_hi(int ln, bit fc); return fc ? host_hi[ln] : card_hi[ln]; endfunction
  function automatic int m_any(int ln, bit fc);
    return fc ? (card_lo[ln] | card_hi[ln]) : (host_lo[ln] | host_hi[ln]);
  endfunction
  function automatic int others(int ln);
    logic [LANES-1:0] m = ~(LANES'(1) << ln);
    return int'(|((host_lo | host_hi | card_lo | card_hi) & m));
  endfunction
  function automatic int all_any();
    return int'(|(host_lo | host_hi | card_lo | card_hi));
  endfunction

  task automatic drive(int ln, bit fc, bit v);
    if (fc) card_ext[ln] = v; else host_ext[ln] = v;
  endtask

  task automatic xfer(int ln, bit fc, int low_len);
    @(negedge clk); drive(ln, fc, 1'b1);
    repeat (EDGE + 2) @(posedge clk);
    #1 chk("R3 slave low not yet", s_lo(ln, fc), 0);
    @(posedge clk);
    #1 chk("R3 slave low on time", s_lo(ln, fc), 1);
    chk("R2 master side quiet", m_any(ln, fc), 0);
    chk("R10 other lanes idle", others(ln), 0);
    repeat (low_len - (EDGE + 3)) @(posedge clk);
    #1 chk("R4 slave held low", s_lo(ln, fc), 1);
    chk("R4 master side locked", m_any(ln, fc), 0);
    @(negedge clk); drive(ln, fc, 1'b0);
    repeat (2) @(posedge clk);
    #1 chk("R5 low kept before release seen", s_lo(ln, fc), 1);
    chk("R5 no boost yet", s_hi(ln, fc), 0);
    @(posedge clk);
    #1 chk("R5 low dropped", s_lo(ln, fc), 0);
    chk("R5 boost on", s_hi(ln, fc), 1);
    repeat (EDGE - 1) @(posedge clk);
    #1 chk("R5 boost lasts EDGE_DLY", s_hi(ln, fc), 1);
    @(posedge clk);
    #1 chk("R5 boost ended", s_hi(ln, fc), 0);
    chk("R1 lane idle after transfer", all_any(), 0);
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    int seen;
    repeat (3) @(posedge clk);
    #1 chk("R1 reset state", all_any(), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1 chk("R1 idle after reset", all_any(), 0);

    for (int v = 0; v < NVEC; v++) xfer(VEC[v][0], VEC[v][1] != 0, VEC[v][2]);

    // R2: same-cycle falls, host wins
    @(negedge clk); host_ext[1] = 1'b1; card_ext[1] = 1'b1;
    repeat (EDGE + 3) @(posedge clk);
    #1 chk("R2 tie host wins card low", card_lo[1], 1);
    chk("R2 tie host side quiet", host_lo[1] | host_hi[1], 0);
    @(negedge clk); host_ext[1] = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk("R2 tie boost to card", card_hi[1], 1);
    @(negedge clk); card_ext[1] = 1'b0;
    repeat (EDGE + 5) @(posedge clk);
    #1 chk("R1 idle after tie", all_any(), 0);

    // R7: short master pulse
    @(negedge clk); host_ext[2] = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk); host_ext[2] = 1'b0;
    seen = 0;
    repeat (EDGE + 10) begin @(posedge clk); #1 seen |= all_any(); end
    chk("R7 short pulse drives nothing", seen, 0);

    // R8: re-fall during boost is lost
    @(negedge clk); host_ext[0] = 1'b1;
    repeat (EDGE + 8) @(posedge clk);
    @(negedge clk); host_ext[0] = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk("R8 boost running", card_hi[0], 1);
    @(negedge clk); host_ext[0] = 1'b1;
    repeat (EDGE + 2) @(posedge clk);
    seen = 0;
    repeat (EDGE + 10) begin @(posedge clk); #1 seen |= card_lo[0]; end
    chk("R8 fall during boost ignored", seen, 0);
    @(negedge clk); host_ext[0] = 1'b0;
    repeat (5) @(posedge clk);
    xfer(0, 1'b0, 60);

    // R9: session drop mid-copy
    @(negedge clk); host_ext[1] = 1'b1;
    repeat (EDGE + 3) @(posedge clk);
    #1 chk("R9 copy active before drop", card_lo[1], 1);
    @(negedge clk); sess = 1'b0;
    @(posedge clk);
    #1 chk("R9 drivers off at once", all_any(), 0);
    @(negedge clk); host_ext[1] = 1'b0; card_ext[2] = 1'b1;
    seen = 0;
    repeat (EDGE + 10) begin @(posedge clk); #1 seen |= all_any(); end
    chk("R9 nothing while session off", seen, 0);
    @(negedge clk); sess = 1'b1; card_ext[2] = 1'b0;
    repeat (10) @(posedge clk);
    #1 chk("R9 idle after session back", all_any(), 0);
    xfer(2, 1'b1, 70);

    report();
    $finish;
  end
endmodule